// File: doc/BRIEF.md
# Speculative Block Sequencer

This is the global controller for a machine that runs programs as atomic blocks. Each block holds up to 128 instructions. The sequencer requests blocks one at a time from the fetch unit. The address of each new block is taken speculatively from a next-block predictor, so the front end can run ahead of execution. Every fetched block gets a slot ID from a circular pool of `NUM_SLOTS` entries (8 by default), and IDs are handed out round-robin. When the fetch unit reports that a block has arrived, the sequencer records the predicted successor address, pulses the dispatch enable of that slot, and points the fetch address at the prediction.

While a block executes, the execution tiles report two things per slot ID: that all of its register writes and stores have been produced, and that its single branch exit has resolved to a target address. A block retires only when it is the oldest in flight and both reports are in, so commits come out in allocation order.

Two events discard speculative work:
- **Exit mismatch.** If a resolved exit differs from the successor that was predicted for that block, every younger slot is flushed in a single cycle and fetch restarts at the resolved target.
- **Fault.** A fault reported against a block marks it. Once the marked block is the oldest, every block in flight is flushed and fetch restarts at the faulting block's own address, so the whole block runs again.

Top module: `spec_block_seq`

## Requirements
- R1: While reset is high, fetch_req_o, dispatch_en_o, commit_vld_o and flush_vld_o are all low. The first fetch after reset carries address RESET_ADDR and slot ID 0.
- R2: At most one fetch is outstanding, meaning no new fetch_req_o is issued until the previous one has been dispatched or flushed. Slot IDs advance by one modulo NUM_SLOTS. Each fetch address is the predicted successor captured when the previous block was dispatched, unless a flush has redirected it.
- R3: The number of blocks in flight, counting both fetching and executing blocks, never exceeds NUM_SLOTS.
- R4: One cycle after fetch_done_i is accepted, dispatch_en_o is one-hot with bit k set, where k is the slot ID of the outstanding fetch.
- R5: A block commits only after both its outputs report and its exit report have been accepted.
- R6: Only the oldest block may commit, so commit_id_o follows allocation order. The oldest block commits no later than two cycles after its last completion report.
- R7: An exit whose target differs from the block's recorded prediction raises flush_vld_o in the next cycle. In that cycle flush_mask_o has bit k set for exactly the slots younger than the resolving block. The next fetch then carries the resolved target and the slot ID that follows the resolving block.
- R8: A fault marks its block. Two cycles after the marked block has become the oldest, flush_vld_o is high and flush_mask_o covers every block in flight. The next fetch then carries the faulting block's address and its slot ID.
- R9: An outputs, exit or fault report for a slot that is not executing is ignored, and so is a second exit report for a block whose exit has already resolved. Such a report raises no flush and commits nothing.
- R10: A fetch_done_i that arrives in the same cycle as a flush covering the fetching slot is dropped, and no dispatch_en_o follows. A fault flush takes precedence over an exit mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_o | output | 1 | One-cycle pulse requesting a block fetch |
| fetch_addr_o | output | ADDR_W | Address of the requested block |
| fetch_id_o | output | ID_W | Slot ID assigned to the requested block |
| fetch_done_i | input | 1 | The outstanding fetch has arrived |
| pred_addr_i | input | ADDR_W | Predicted successor address, valid with fetch_done_i |
| dispatch_en_o | output | NUM_SLOTS | One-hot dispatch enable for the slot just fetched |
| outs_vld_i | input | 1 | All outputs of a block have been produced |
| outs_id_i | input | ID_W | Slot ID for outs_vld_i |
| exit_vld_i | input | 1 | The branch exit of a block has resolved |
| exit_id_i | input | ID_W | Slot ID for exit_vld_i |
| exit_tgt_i | input | ADDR_W | Resolved target address of that exit |
| exc_vld_i | input | 1 | A fault occurred in a block |
| exc_id_i | input | ID_W | Slot ID for exc_vld_i |
| commit_vld_o | output | 1 | One-cycle pulse committing the oldest block |
| commit_id_o | output | ID_W | Slot ID being committed |
| flush_vld_o | output | 1 | One-cycle pulse announcing a flush and fetch redirect |
| flush_mask_o | output | NUM_SLOTS | Slots discarded by this flush |

## Verification
The bench targets an exit mismatch that arrives in the same cycle as the fetch_done of the younger block still being fetched. A design that got this wrong would dispatch a block that had just been discarded, or would leave the fetch pointer on the wrong path. It also drives mismatches on the youngest executing block, where the mask must be empty but fetch still has to be redirected, and on blocks sitting behind a committing head, where the truncation must account for the pop. Faults are raised against blocks that are not yet the oldest. A design that flushed early would break block-level precision, and one that forgot the mark would commit a faulted block. Stale exit reports and reports against free slots are mixed in, so a design that skipped the slot-phase check would produce flushes nobody asked for.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_FETCH = 2'd1,
    SLOT_EXEC  = 2'd2
  } slot_phase_e;
endpackage

// File: rtl/sbs_ring_ptr.sv
// Head/tail/occupancy of the circular slot pool. NUM_SLOTS must be a power of two.
module sbs_ring_ptr #(
  parameter int NUM_SLOTS = 8,
  localparam int ID_W  = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_i,
  input  logic             pop_i,
  input  logic             trunc_i,
  input  logic [ID_W-1:0]  trunc_id_i,
  input  logic             clear_i,
  output logic [ID_W-1:0]  head_o,
  output logic [ID_W-1:0]  tail_o,
  output logic [CNT_W-1:0] count_o
);
  logic [ID_W-1:0]  head_q, tail_q, head_n, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    cnt_n  = cnt_q;
    if (clear_i) begin
      // full discard: refetch reuses the oldest slot
      tail_n = head_q;
      cnt_n  = '0;
    end else if (trunc_i) begin
      // keep everything up to and including the resolving block
      tail_n = trunc_id_i + ID_W'(1);
      head_n = head_q + ID_W'(pop_i);
      cnt_n  = CNT_W'(ID_W'(trunc_id_i - head_q)) + CNT_W'(1) - CNT_W'(pop_i);
    end else begin
      head_n = head_q + ID_W'(pop_i);
      tail_n = tail_q + ID_W'(alloc_i);
      cnt_n  = cnt_q + CNT_W'(alloc_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/sbs_age_mask.sv
// Per-slot liveness and "younger than ref_id" masks relative to the ring head.
module sbs_age_mask #(
  parameter int NUM_SLOTS = 8,
  localparam int ID_W  = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic [ID_W-1:0]      head_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic [ID_W-1:0]      ref_id_i,
  output logic [NUM_SLOTS-1:0] live_o,
  output logic [NUM_SLOTS-1:0] younger_o
);
  logic [ID_W-1:0] ref_rel;
  assign ref_rel = ref_id_i - head_i;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_age
    logic [ID_W-1:0] rel;
    assign rel          = ID_W'(i) - head_i;
    assign live_o[i]    = CNT_W'(rel) < count_i;
    assign younger_o[i] = live_o[i] && (rel > ref_rel);
  end
endmodule

// File: rtl/sbs_slot_bank.sv
// Slot storage: address/prediction memories (one write port each) and per-slot status.
module sbs_slot_bank
  import sbs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 16,
  localparam int ID_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc_we_i,
  input  logic [ID_W-1:0]      alloc_idx_i,
  input  logic [ADDR_W-1:0]    alloc_addr_i,
  input  logic                 disp_we_i,
  input  logic [ID_W-1:0]      disp_idx_i,
  input  logic [ADDR_W-1:0]    disp_pred_i,
  input  logic                 outs_vld_i,
  input  logic [ID_W-1:0]      outs_id_i,
  input  logic                 exit_vld_i,
  input  logic [ID_W-1:0]      exit_id_i,
  input  logic                 exc_vld_i,
  input  logic [ID_W-1:0]      exc_id_i,
  input  logic [NUM_SLOTS-1:0] clear_i,
  input  logic [ID_W-1:0]      rd_addr_idx_i,
  output logic [ADDR_W-1:0]    rd_addr_o,
  input  logic [ID_W-1:0]      rd_pred_idx_i,
  output logic [ADDR_W-1:0]    rd_pred_o,
  output logic [NUM_SLOTS-1:0] exec_o,
  output logic [NUM_SLOTS-1:0] outs_o,
  output logic [NUM_SLOTS-1:0] exit_o,
  output logic [NUM_SLOTS-1:0] exc_o
);
  logic [ADDR_W-1:0] addr_mem [NUM_SLOTS];
  logic [ADDR_W-1:0] pred_mem [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (alloc_we_i) addr_mem[alloc_idx_i] <= alloc_addr_i;
  end

  always_ff @(posedge clk) begin
    if (disp_we_i) pred_mem[disp_idx_i] <= disp_pred_i;
  end

  assign rd_addr_o = addr_mem[rd_addr_idx_i];
  assign rd_pred_o = pred_mem[rd_pred_idx_i];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_phase_e phase_q;
    logic        outs_q, exit_q, exc_q;
    logic        running;
    assign running = (phase_q == SLOT_EXEC);

    always_ff @(posedge clk) begin
      if (rst || clear_i[i]) begin
        phase_q <= SLOT_FREE;
        outs_q  <= 1'b0;
        exit_q  <= 1'b0;
        exc_q   <= 1'b0;
      end else if (alloc_we_i && alloc_idx_i == ID_W'(i)) begin
        phase_q <= SLOT_FETCH;
        outs_q  <= 1'b0;
        exit_q  <= 1'b0;
        exc_q   <= 1'b0;
      end else begin
        if (disp_we_i && disp_idx_i == ID_W'(i)) phase_q <= SLOT_EXEC;
        if (running && outs_vld_i && outs_id_i == ID_W'(i)) outs_q <= 1'b1;
        if (running && exit_vld_i && exit_id_i == ID_W'(i)) exit_q <= 1'b1;
        if (running && exc_vld_i && exc_id_i == ID_W'(i)) exc_q <= 1'b1;
      end
    end

    assign exec_o[i] = running;
    assign outs_o[i] = outs_q;
    assign exit_o[i] = exit_q;
    assign exc_o[i]  = exc_q;
  end
endmodule

// File: rtl/spec_block_seq.sv
module spec_block_seq #(
  parameter int              NUM_SLOTS  = 8,
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0100,
  localparam int ID_W  = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 fetch_req_o,
  output logic [ADDR_W-1:0]    fetch_addr_o,
  output logic [ID_W-1:0]      fetch_id_o,
  input  logic                 fetch_done_i,
  input  logic [ADDR_W-1:0]    pred_addr_i,
  output logic [NUM_SLOTS-1:0] dispatch_en_o,
  input  logic                 outs_vld_i,
  input  logic [ID_W-1:0]      outs_id_i,
  input  logic                 exit_vld_i,
  input  logic [ID_W-1:0]      exit_id_i,
  input  logic [ADDR_W-1:0]    exit_tgt_i,
  input  logic                 exc_vld_i,
  input  logic [ID_W-1:0]      exc_id_i,
  output logic                 commit_vld_o,
  output logic [ID_W-1:0]      commit_id_o,
  output logic                 flush_vld_o,
  output logic [NUM_SLOTS-1:0] flush_mask_o
);
  logic [ID_W-1:0]      head, tail;
  logic [CNT_W-1:0]     count;
  logic [NUM_SLOTS-1:0] exec_v, outs_v, exit_v, exc_v, live_v, younger_v;
  logic [ADDR_W-1:0]    head_addr, exit_pred;

  logic [ADDR_W-1:0] pc_q, pc_n;
  logic              busy_q, busy_n;
  logic [ID_W-1:0]   fslot_q;

  logic head_exec, exc_flush, commit_ok, exit_ok, mispredict;
  logic fetch_kill, done_ok, alloc;
  logic [NUM_SLOTS-1:0] flush_n, clear_v, head_oh, fslot_oh;

  sbs_ring_ptr #(.NUM_SLOTS(NUM_SLOTS)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .alloc_i    (alloc),
    .pop_i      (commit_ok),
    .trunc_i    (mispredict),
    .trunc_id_i (exit_id_i),
    .clear_i    (exc_flush),
    .head_o     (head),
    .tail_o     (tail),
    .count_o    (count)
  );

  sbs_age_mask #(.NUM_SLOTS(NUM_SLOTS)) u_age (
    .head_i    (head),
    .count_i   (count),
    .ref_id_i  (exit_id_i),
    .live_o    (live_v),
    .younger_o (younger_v)
  );

  sbs_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_bank (
    .clk           (clk),
    .rst           (rst),
    .alloc_we_i    (alloc),
    .alloc_idx_i   (tail),
    .alloc_addr_i  (pc_q),
    .disp_we_i     (done_ok),
    .disp_idx_i    (fslot_q),
    .disp_pred_i   (pred_addr_i),
    .outs_vld_i    (outs_vld_i),
    .outs_id_i     (outs_id_i),
    .exit_vld_i    (exit_vld_i),
    .exit_id_i     (exit_id_i),
    .exc_vld_i     (exc_vld_i),
    .exc_id_i      (exc_id_i),
    .clear_i       (clear_v),
    .rd_addr_idx_i (head),
    .rd_addr_o     (head_addr),
    .rd_pred_idx_i (exit_id_i),
    .rd_pred_o     (exit_pred),
    .exec_o        (exec_v),
    .outs_o        (outs_v),
    .exit_o        (exit_v),
    .exc_o         (exc_v)
  );

  assign head_oh  = NUM_SLOTS'(1) << head;
  assign fslot_oh = NUM_SLOTS'(1) << fslot_q;

  always_comb begin
    head_exec  = (count != '0) && exec_v[head];
    exc_flush  = head_exec && exc_v[head];
    commit_ok  = head_exec && outs_v[head] && exit_v[head] && !exc_v[head];
    exit_ok    = exit_vld_i && exec_v[exit_id_i] && !exit_v[exit_id_i];
    mispredict = exit_ok && (exit_tgt_i != exit_pred) && !exc_flush;

    if (exc_flush)       flush_n = live_v;
    else if (mispredict) flush_n = younger_v;
    else                 flush_n = '0;

    clear_v    = flush_n | (commit_ok ? head_oh : '0);
    fetch_kill = busy_q && flush_n[fslot_q];
    done_ok    = busy_q && fetch_done_i && !fetch_kill;
    alloc      = !busy_q && (count < CNT_W'(NUM_SLOTS)) && !exc_flush && !mispredict;

    if (alloc)                      busy_n = 1'b1;
    else if (done_ok || fetch_kill) busy_n = 1'b0;
    else                            busy_n = busy_q;

    if (exc_flush)       pc_n = head_addr;
    else if (mispredict) pc_n = exit_tgt_i;
    else if (done_ok)    pc_n = pred_addr_i;
    else                 pc_n = pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q          <= RESET_ADDR;
      busy_q        <= 1'b0;
      fslot_q       <= '0;
      fetch_req_o   <= 1'b0;
      fetch_addr_o  <= '0;
      fetch_id_o    <= '0;
      dispatch_en_o <= '0;
      commit_vld_o  <= 1'b0;
      commit_id_o   <= '0;
      flush_vld_o   <= 1'b0;
      flush_mask_o  <= '0;
    end else begin
      pc_q          <= pc_n;
      busy_q        <= busy_n;
      fetch_req_o   <= alloc;
      dispatch_en_o <= done_ok ? fslot_oh : '0;
      commit_vld_o  <= commit_ok;
      flush_vld_o   <= exc_flush || mispredict;
      flush_mask_o  <= flush_n;
      if (alloc) begin
        fslot_q      <= tail;
        fetch_addr_o <= pc_q;
        fetch_id_o   <= tail;
      end
      if (commit_ok) commit_id_o <= head;
    end
  end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int NUM_SLOTS = 8,
  localparam int ID_W  = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fetch_req_o,
  input logic                 fetch_done_i,
  input logic [NUM_SLOTS-1:0] dispatch_en_o,
  input logic                 commit_vld_o,
  input logic [ID_W-1:0]      commit_id_o,
  input logic                 flush_vld_o,
  input logic [NUM_SLOTS-1:0] flush_mask_o,
  input logic [CNT_W-1:0]     count
);
  // R3
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(NUM_SLOTS));

  // R2
  single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req_o |=> !fetch_req_o);

  // R4
  dispatch_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dispatch_en_o));

  // R4
  dispatch_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    (dispatch_en_o != '0) |-> $past(fetch_done_i));

  // R6
  commit_survives_chk: assert property (@(posedge clk) disable iff (rst)
    commit_vld_o |-> !flush_mask_o[commit_id_o]);

  // R10
  no_fetch_on_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush_vld_o |-> !fetch_req_o);
endmodule

bind spec_block_seq sbs_checker #(.NUM_SLOTS(NUM_SLOTS)) u_sbs_checker (
  .clk           (clk),
  .rst           (rst),
  .fetch_req_o   (fetch_req_o),
  .fetch_done_i  (fetch_done_i),
  .dispatch_en_o (dispatch_en_o),
  .commit_vld_o  (commit_vld_o),
  .commit_id_o   (commit_id_o),
  .flush_vld_o   (flush_vld_o),
  .flush_mask_o  (flush_mask_o),
  .count         (count)
);

// File: tb/tb_spec_block_seq.sv
`timescale 1ns/100ps
module tb_spec_block_seq;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int IW = $clog2(N);
  localparam logic [AW-1:0] RST_PC = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          fetch_req, fetch_done, outs_vld, exit_vld, exc_vld, commit_vld, flush_vld;
  logic [AW-1:0] fetch_addr, pred_addr, exit_tgt;
  logic [IW-1:0] fetch_id, outs_id, exit_id, exc_id, commit_id;
  logic [N-1:0]  dispatch_en, flush_mask;

  spec_block_seq #(.NUM_SLOTS(N), .ADDR_W(AW), .RESET_ADDR(RST_PC)) dut (
    .clk(clk), .rst(rst),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_id_o(fetch_id),
    .fetch_done_i(fetch_done), .pred_addr_i(pred_addr),
    .dispatch_en_o(dispatch_en),
    .outs_vld_i(outs_vld), .outs_id_i(outs_id),
    .exit_vld_i(exit_vld), .exit_id_i(exit_id), .exit_tgt_i(exit_tgt),
    .exc_vld_i(exc_vld), .exc_id_i(exc_id),
    .commit_vld_o(commit_vld), .commit_id_o(commit_id),
    .flush_vld_o(flush_vld), .flush_mask_o(flush_mask)
  );

  typedef struct {
    logic [IW-1:0] id;
    logic [AW-1:0] addr;
    logic [AW-1:0] pred;
    bit disp, outs, ext, exc;
  } ent_t;

  ent_t q[$];
  int checks = 0, fails = 0, commits = 0, mis_seen = 0, exc_seen = 0;
  logic [AW-1:0] exp_pc = RST_PC;
  logic [IW-1:0] exp_id = '0;
  bit first_fetch = 1'b1;
  bit fd_pend = 0, mis_pend = 0, quiet_chk = 0;
  logic [IW-1:0] fd_id, mis_id;
  logic [AW-1:0] fd_pred, mis_tgt;
  int hr_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int find_id(input logic [IW-1:0] id);
    for (int i = 0; i < q.size(); i++) if (q[i].id == id) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] rand_pc();
    return AW'(($urandom % 256) * 4);
  endfunction

  task automatic observe();
    bit head_ok;
    logic [N-1:0] m;
    int k;
    if (quiet_chk) chk(!flush_vld, "R9", "stale exit raised flush", 32'(flush_vld), 0);
    quiet_chk = 0;
    // commit, R5/R6
    head_ok = (q.size() > 0) && q[0].disp && q[0].outs && q[0].ext && !q[0].exc;
    if (commit_vld) begin
      if (q.size() == 0) chk(0, "R6", "commit with nothing in flight", 32'(commit_id), 0);
      else begin
        chk(commit_id == q[0].id, "R6", "commit id not oldest", 32'(commit_id), 32'(q[0].id));
        chk(head_ok, "R5", "commit of incomplete block", 0, 1);
        void'(q.pop_front());
        commits++;
      end
      hr_cnt = 0;
    end else if (head_ok && hr_cnt >= 2) begin
      chk(0, "R6", "oldest complete block not committed", 0, 1);
      hr_cnt = 0;
    end
    // flush, R7/R8
    if (flush_vld) begin
      m = '0;
      if (mis_pend) begin
        k = find_id(mis_id);
        for (int i = k + 1; i < q.size(); i++) m[q[i].id] = 1'b1;
        chk(flush_mask == m, "R7", "mispredict flush mask", 32'(flush_mask), 32'(m));
        while (q.size() > k + 1) void'(q.pop_back());
        exp_pc = mis_tgt;
        exp_id = mis_id + IW'(1);
        mis_seen++;
      end else if (q.size() > 0 && q[0].exc) begin
        for (int i = 0; i < q.size(); i++) m[q[i].id] = 1'b1;
        chk(flush_mask == m, "R8", "fault flush mask", 32'(flush_mask), 32'(m));
        exp_pc = q[0].addr;
        exp_id = q[0].id;
        q.delete();
        exc_seen++;
      end else chk(0, "R7", "unexpected flush", 32'(flush_mask), 0);
      hr_cnt = 0;
    end else if (mis_pend) chk(0, "R7", "mispredict flush missing", 0, 1);
    else if (q.size() > 0 && q[0].exc && hr_cnt >= 2) begin
      chk(0, "R8", "fault flush missing", 0, 1);
      hr_cnt = 0;
    end
    mis_pend = 0;
    // dispatch, R4/R10
    if (dispatch_en != '0) begin
      if (!fd_pend) chk(0, "R4", "dispatch without fetch_done", 32'(dispatch_en), 0);
      else begin
        chk(dispatch_en == (N'(1) << fd_id), "R4", "dispatch enable", 32'(dispatch_en), 32'(N'(1) << fd_id));
        k = find_id(fd_id);
        if (k >= 0) begin q[k].disp = 1; q[k].pred = fd_pred; end
        exp_pc = fd_pred;
      end
    end else if (fd_pend) begin
      k = find_id(fd_id);
      chk(!(k >= 0 && !q[k].disp), "R10", "fetch_done lost without flush", 0, 1);
    end
    fd_pend = 0;
    // fetch, R1/R2/R3
    if (fetch_req) begin
      k = 0;
      for (int i = 0; i < q.size(); i++) if (!q[i].disp) k = 1;
      chk(k == 0, "R2", "second fetch while one outstanding", 1, 0);
      chk(q.size() < N, "R3", "in-flight count over capacity", 32'(q.size()), N);
      if (first_fetch)
        chk(fetch_addr == RST_PC && fetch_id == '0, "R1", "first fetch", 32'(fetch_addr), 32'(RST_PC));
      first_fetch = 0;
      chk(fetch_addr == exp_pc, "R2", "fetch address", 32'(fetch_addr), 32'(exp_pc));
      chk(fetch_id == exp_id, "R2", "fetch id", 32'(fetch_id), 32'(exp_id));
      q.push_back('{id: fetch_id, addr: fetch_addr, pred: '0, disp: 0, outs: 0, ext: 0, exc: 0});
      exp_id = exp_id + IW'(1);
    end
  endtask

  task automatic drive();
    int cand[$];
    int k;
    bit any_exc, did_exc;
    fetch_done = 0; outs_vld = 0; exit_vld = 0; exc_vld = 0;
    k = -1;
    for (int i = 0; i < q.size(); i++) if (!q[i].disp) k = i;
    if (k >= 0 && ($urandom % 3 == 0)) begin
      fetch_done = 1; pred_addr = rand_pc();
      fd_pend = 1; fd_id = q[k].id; fd_pred = pred_addr;
    end
    did_exc = 0;
    cand.delete();
    for (int i = 0; i < q.size(); i++)
      if (q[i].disp && !q[i].exc && !(q[i].outs && q[i].ext)) cand.push_back(i);
    if (cand.size() > 0 && ($urandom % 48 == 0)) begin
      k = cand[$urandom % cand.size()];
      exc_vld = 1; exc_id = q[k].id; q[k].exc = 1; did_exc = 1;
    end
    any_exc = 0;
    for (int i = 0; i < q.size(); i++) if (q[i].exc) any_exc = 1;
    cand.delete();
    for (int i = 0; i < q.size(); i++) if (q[i].disp && !q[i].ext && !q[i].exc) cand.push_back(i);
    if (cand.size() > 0 && ($urandom % 2 == 0)) begin
      k = cand[$urandom % cand.size()];
      exit_vld = 1; exit_id = q[k].id; exit_tgt = q[k].pred; q[k].ext = 1;
      if (!any_exc && ($urandom % 8 == 0)) begin
        exit_tgt = q[k].pred ^ AW'(16'h0400);
        mis_pend = 1; mis_id = q[k].id; mis_tgt = exit_tgt;
      end
    end else if (!any_exc && ($urandom % 12 == 0)) begin
      cand.delete();
      for (int i = 0; i < q.size(); i++) if (q[i].ext) cand.push_back(i);
      if (cand.size() > 0) begin
        k = cand[$urandom % cand.size()];
        exit_vld = 1; exit_id = q[k].id; exit_tgt = q[k].pred ^ AW'(16'h0800);
        quiet_chk = 1;   // R9: second exit must be ignored
      end
    end
    cand.delete();
    for (int i = 0; i < q.size(); i++) if (q[i].disp && !q[i].outs && !q[i].exc) cand.push_back(i);
    if (cand.size() > 0 && ($urandom % 2 == 0)) begin
      k = cand[$urandom % cand.size()];
      outs_vld = 1; outs_id = q[k].id; q[k].outs = 1;
    end
    if (q.size() > 0 && (q[0].exc || (q[0].disp && q[0].outs && q[0].ext))) hr_cnt++;
    else hr_cnt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EB1_0C77));
    fetch_done = 0; pred_addr = '0; outs_vld = 0; outs_id = '0;
    exit_vld = 0; exit_id = '0; exit_tgt = '0; exc_vld = 0; exc_id = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!fetch_req && dispatch_en == '0 && !commit_vld && !flush_vld, "R1",
        "strobes during reset", {fetch_req, commit_vld, flush_vld}, 0);
    rst = 0;
    // R9 directed: exit report for a slot that holds no block
    exit_vld = 1; exit_id = IW'(5); exit_tgt = 16'hBEEC;
    quiet_chk = 1;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      observe();
      drive();
    end
    fetch_done = 0; outs_vld = 0; exit_vld = 0; exc_vld = 0;
    chk(commits > 200, "R6", "commit progress", commits, 200);
    chk(mis_seen > 5, "R7", "mispredict coverage", mis_seen, 5);
    chk(exc_seen > 2, "R8", "fault coverage", exc_seen, 2);
    finish_run();
  end
endmodule